// File: doc/BRIEF.md
# Five-Stage Pipelined Six-Instruction Processor Core

This block is a 32-bit in-order processor core split into five stages: fetch, decode and register read, execute, memory access and register write-back. It recognises six operations: register add and subtract (both wrapping), OR with a zero-extended immediate, word load, word store and branch-on-equal. A register stage sits at each of the four boundaries between stages. Each instruction travels through those registers together with the decoded control bits and the number of the register it will write, so every stage in a cycle works on a different instruction.

The core has no hazard interlock, no forwarding and no stall. Software must leave at least two instructions between the one that writes a register and any later one that reads it. A branch is resolved in the memory stage, so the three instructions that follow it are always executed. Instruction and data memories sit outside the core: it presents a fetch address and a data address, and reads back words combinationally. A separate read port on the register file lets the environment inspect register contents.

Top module: `pipe5_core`

## Requirements
- R1: While reset is active and in the first cycle after it, the fetch address is 0 and the data-memory write strobe is 0. Reset empties the pipeline to no-operations and clears every register to 0.
- R2: The core fetches a new instruction every cycle. When no taken branch is in the memory stage, the next fetch address is the current one plus 4.
- R3: An instruction with opcode field [31:26] = 0x00 and function field [5:0] = 0x21 writes rs+rt to rd. With function 0x23 it writes rs−rt to rd. Both wrap modulo 2^32. rs is [25:21], rt is [20:16] and rd is [15:11].
- R4: Opcode 0x0D writes rs OR the 16-bit immediate [15:0], zero-extended, to rt.
- R5: Opcode 0x23 loads the word at rs+sign-extended immediate into rt. Opcode 0x2B stores rt to that address. The write strobe, address and data for a store appear on the data-memory port exactly 3 cycles after the cycle in which the store was fetched.
- R6: Opcode 0x04 compares rs and rt. If they are equal, the instruction fetched 4 cycles after the branch comes from branch address + 4 + (sign-extended immediate × 4). The three instructions fetched after the branch are executed either way.
- R7: Each register write goes to the destination of the instruction in write-back, 4 cycles after that instruction was fetched. The fields of the instruction then in decode play no part.
- R8: A register read in decode returns the value being written by write-back in the same cycle, so a gap of two instructions between producer and consumer is enough.
- R9: Register 0 always reads as 0, and writes to it are discarded.
- R10: Any other encoding, including the all-zero word, writes no register, does not write memory and does not redirect fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address for the load or store in the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written on the rising edge |
| dmem_rdata | input | 32 | Word at dmem_addr, same cycle |
| dbg_raddr | input | 5 | Register number for the inspection read port |
| dbg_rdata | output | 32 | Contents of register dbg_raddr |

## Verification
The bound checker covers the timing relations on every cycle. It checks the reset fetch address and the quiet store strobe, the +4 fetch step, the redirect to the resolved target one cycle after a taken branch, the two-cycle lag from a decoded store to the memory strobe, and the three-cycle lag from a decoded register write to the write-back of the same destination. The arithmetic results, load data, same-cycle write-then-read behaviour, register 0, the delay slots and the handling of unknown encodings show only in the bench. The bench runs a program against a behavioural stage-by-stage model, compares the fetch address and store traffic every cycle, and then compares the whole register file and data memory.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_ORI   = 6'h0D;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] FN_ADDU  = 6'h21;
   localparam logic [5:0] FN_SUBU  = 6'h23;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_OR  = 2'd2
   } alu_op_e;

   typedef struct packed {
      logic    reg_we;
      logic    mem_we;
      logic    mem_to_reg;
      logic    dst_rd;
      logic    use_imm;
      logic    imm_signed;
      logic    is_branch;
      alu_op_e alu_op;
   } ctrl_t;

   localparam ctrl_t CTRL_NOP = '0;

endpackage

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl
   import pipe5_pkg::*;
(
   input  logic [5:0] op,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);
   always_comb begin
      ctrl = CTRL_NOP;
      case (op)
         OP_RTYPE: begin
            if (funct == FN_ADDU) begin
               ctrl.reg_we = 1'b1;
               ctrl.dst_rd = 1'b1;
               ctrl.alu_op = ALU_ADD;
            end else if (funct == FN_SUBU) begin
               ctrl.reg_we = 1'b1;
               ctrl.dst_rd = 1'b1;
               ctrl.alu_op = ALU_SUB;
            end
         end
         OP_ORI: begin
            ctrl.reg_we  = 1'b1;
            ctrl.use_imm = 1'b1;
            ctrl.alu_op  = ALU_OR;
         end
         OP_LW: begin
            ctrl.reg_we     = 1'b1;
            ctrl.use_imm    = 1'b1;
            ctrl.imm_signed = 1'b1;
            ctrl.mem_to_reg = 1'b1;
            ctrl.alu_op     = ALU_ADD;
         end
         OP_SW: begin
            ctrl.mem_we     = 1'b1;
            ctrl.use_imm    = 1'b1;
            ctrl.imm_signed = 1'b1;
            ctrl.alu_op     = ALU_ADD;
         end
         OP_BEQ: begin
            ctrl.is_branch  = 1'b1;
            ctrl.imm_signed = 1'b1;
            ctrl.alu_op     = ALU_SUB;
         end
         default: ctrl = CTRL_NOP;
      endcase
   end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
   import pipe5_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_op_e           op,
   output logic [DATA_W-1:0] y,
   output logic              zero
);
   always_comb begin
      case (op)
         ALU_SUB: y = a - b;
         ALU_OR:  y = a | b;
         default: y = a + b;
      endcase
   end
   assign zero = (y == '0);
endmodule

// File: rtl/pipe5_rf.sv
module pipe5_rf #(
   parameter int DATA_W    = 32,
   parameter int REG_N     = 32,
   parameter bit HARD_ZERO = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(REG_N)-1:0] waddr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [$clog2(REG_N)-1:0] ra1,
   output logic [DATA_W-1:0]        rd1,
   input  logic [$clog2(REG_N)-1:0] ra2,
   output logic [DATA_W-1:0]        rd2,
   input  logic [$clog2(REG_N)-1:0] ra3,
   output logic [DATA_W-1:0]        rd3
);
   localparam int AW = $clog2(REG_N);

   logic [DATA_W-1:0] regs [REG_N];
   logic              wr_ok;

   generate
      if (HARD_ZERO) begin : g_zero
         assign wr_ok = we && (waddr != '0);
      end else begin : g_plain
         assign wr_ok = we;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_N; i++) regs[i] <= '0;
      end else if (wr_ok) begin
         regs[waddr] <= wdata;
      end
   end

   function automatic logic [DATA_W-1:0] rd_thru(input logic [AW-1:0] a);
      return (wr_ok && (waddr == a)) ? wdata : regs[a];
   endfunction

   assign rd1 = rd_thru(ra1);
   assign rd2 = rd_thru(ra2);
   assign rd3 = rd_thru(ra3);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
   import pipe5_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          REG_N     = 32,
   parameter logic [31:0] RESET_PC  = 32'h0,
   parameter bit          HARD_ZERO = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [31:0] imem_addr,
   input  logic [31:0] imem_rdata,
   output logic [31:0] dmem_addr,
   output logic [31:0] dmem_wdata,
   output logic        dmem_we,
   input  logic [31:0] dmem_rdata,
   input  logic [4:0]  dbg_raddr,
   output logic [31:0] dbg_rdata
);
   localparam int AW  = $clog2(REG_N);
   localparam int EXT = DATA_W - 16;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("pipe5_core: DATA_W must be 32 for this instruction format");
      end
      if (REG_N != 32) begin : g_bad_regs
         $error("pipe5_core: REG_N must be 32 to match 5-bit register fields");
      end
   endgenerate

   // fetch
   logic [DATA_W-1:0] pc_q, pc_next;
   logic              mem_take;
   logic [DATA_W-1:0] exmem_target;
   assign imem_addr = pc_q;
   assign pc_next   = mem_take ? exmem_target : pc_q + DATA_W'(4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= RESET_PC;
      else        pc_q <= pc_next;
   end

   logic [31:0]       ifid_ins;
   logic [DATA_W-1:0] ifid_pc4;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ifid_ins <= '0;
         ifid_pc4 <= '0;
      end else begin
         ifid_ins <= imem_rdata;
         ifid_pc4 <= pc_q + DATA_W'(4);
      end
   end

   // decode
   ctrl_t             id_ctrl;
   logic [4:0]        id_rs, id_rt, id_rd, id_dest;
   logic [DATA_W-1:0] id_a, id_b, id_imm;
   logic              wb_we;
   logic [4:0]        wb_dest;
   logic [DATA_W-1:0] wb_data;

   assign id_rs = ifid_ins[25:21];
   assign id_rt = ifid_ins[20:16];
   assign id_rd = ifid_ins[15:11];

   pipe5_ctrl u_ctrl (
      .op    (ifid_ins[31:26]),
      .funct (ifid_ins[5:0]),
      .ctrl  (id_ctrl)
   );

   assign id_imm  = id_ctrl.imm_signed ? {{EXT{ifid_ins[15]}}, ifid_ins[15:0]}
                                       : {{EXT{1'b0}}, ifid_ins[15:0]};
   assign id_dest = id_ctrl.dst_rd ? id_rd : id_rt;

   pipe5_rf #(.DATA_W(DATA_W), .REG_N(REG_N), .HARD_ZERO(HARD_ZERO)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wb_we),
      .waddr (wb_dest[AW-1:0]),
      .wdata (wb_data),
      .ra1   (id_rs[AW-1:0]),
      .rd1   (id_a),
      .ra2   (id_rt[AW-1:0]),
      .rd2   (id_b),
      .ra3   (dbg_raddr[AW-1:0]),
      .rd3   (dbg_rdata)
   );

   ctrl_t             idex_ctrl;
   logic [DATA_W-1:0] idex_pc4, idex_a, idex_b, idex_imm;
   logic [4:0]        idex_dest;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idex_ctrl <= CTRL_NOP;
         idex_pc4  <= '0;
         idex_a    <= '0;
         idex_b    <= '0;
         idex_imm  <= '0;
         idex_dest <= '0;
      end else begin
         idex_ctrl <= id_ctrl;
         idex_pc4  <= ifid_pc4;
         idex_a    <= id_a;
         idex_b    <= id_b;
         idex_imm  <= id_imm;
         idex_dest <= id_dest;
      end
   end

   // execute
   logic [DATA_W-1:0] ex_y, ex_target;
   logic              ex_zero;

   pipe5_alu #(.DATA_W(DATA_W)) u_alu (
      .a    (idex_a),
      .b    (idex_ctrl.use_imm ? idex_imm : idex_b),
      .op   (idex_ctrl.alu_op),
      .y    (ex_y),
      .zero (ex_zero)
   );
   assign ex_target = idex_pc4 + (idex_imm << 2);

   ctrl_t             exmem_ctrl;
   logic [DATA_W-1:0] exmem_y, exmem_b;
   logic              exmem_zero;
   logic [4:0]        exmem_dest;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exmem_ctrl   <= CTRL_NOP;
         exmem_y      <= '0;
         exmem_b      <= '0;
         exmem_zero   <= 1'b0;
         exmem_target <= '0;
         exmem_dest   <= '0;
      end else begin
         exmem_ctrl   <= idex_ctrl;
         exmem_y      <= ex_y;
         exmem_b      <= idex_b;
         exmem_zero   <= ex_zero;
         exmem_target <= ex_target;
         exmem_dest   <= idex_dest;
      end
   end

   // memory
   assign dmem_addr  = exmem_y;
   assign dmem_wdata = exmem_b;
   assign dmem_we    = exmem_ctrl.mem_we;
   assign mem_take   = exmem_ctrl.is_branch && exmem_zero;

   logic              memwb_m2r;
   logic [DATA_W-1:0] memwb_y, memwb_ld;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_we     <= 1'b0;
         memwb_m2r <= 1'b0;
         memwb_y   <= '0;
         memwb_ld  <= '0;
         wb_dest   <= '0;
      end else begin
         wb_we     <= exmem_ctrl.reg_we;
         memwb_m2r <= exmem_ctrl.mem_to_reg;
         memwb_y   <= exmem_y;
         memwb_ld  <= dmem_rdata;
         wb_dest   <= exmem_dest;
      end
   end

   // write-back
   assign wb_data = memwb_m2r ? memwb_ld : memwb_y;

endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
   import pipe5_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       imem_addr,
   input logic              dmem_we,
   input ctrl_t             id_ctrl,
   input logic [4:0]        id_dest,
   input logic              wb_we,
   input logic [4:0]        wb_dest,
   input logic              mem_take,
   input logic [DATA_W-1:0] mem_target
);
   logic started;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   a_r1_reset_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> (imem_addr == RESET_PC));

   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> !dmem_we);

   a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_take |=> (imem_addr == $past(imem_addr) + 32'd4));

   a_r6_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      mem_take |=> (imem_addr == $past(mem_target)));

   a_r5_store_lag: assert property (@(posedge clk) disable iff (!rst_n)
      id_ctrl.mem_we |-> ##2 dmem_we);

   a_r7_dest_travels: assert property (@(posedge clk) disable iff (!rst_n)
      id_ctrl.reg_we |-> ##3 (wb_we && (wb_dest == $past(id_dest, 3))));
endmodule

bind pipe5_core pipe5_core_chk #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .imem_addr  (imem_addr),
   .dmem_we    (dmem_we),
   .id_ctrl    (id_ctrl),
   .id_dest    (id_dest),
   .wb_we      (wb_we),
   .wb_dest    (wb_dest),
   .mem_take   (mem_take),
   .mem_target (exmem_target)
);

// File: tb/sim_pipe5_core.sv
`timescale 1ns/1ps
module sim_pipe5_core;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] imem_addr, imem_rdata;
   logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;
   logic [4:0]  dbg_raddr;
   logic [31:0] dbg_rdata;

   always #2 clk = ~clk;

   pipe5_core u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata),
      .dbg_raddr  (dbg_raddr),
      .dbg_rdata  (dbg_rdata)
   );

   logic [31:0] imem [64];
   logic [31:0] dmem [64];

   function automatic logic [31:0] fetch_word(input logic [31:0] a);
      return (a < 32'd256) ? imem[a[7:2]] : 32'h0;
   endfunction

   assign imem_rdata = fetch_word(imem_addr);
   assign dmem_rdata = dmem[dmem_addr[7:2]];
   always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
      return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'h00, fn[5:0]};
   endfunction

   function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction

   // behavioural model: five in-flight slots, index 0 = fetch ... 4 = write-back
   logic [31:0] mreg [32];
   logic [31:0] mdm  [64];
   logic [31:0] s_pc [5], s_ins [5], s_a [5], s_b [5], s_res [5];
   logic [31:0] m_pc;

   function automatic int dest_of(input logic [31:0] w);
      if (w[31:26] == 6'h00 && (w[5:0] == 6'h21 || w[5:0] == 6'h23)) return int'(w[15:11]);
      if (w[31:26] == 6'h0D || w[31:26] == 6'h23) return int'(w[20:16]);
      return -1;
   endfunction

   task automatic model_step();
      logic [31:0] w, sx, zx, ea, nxt;
      logic        exp_we;
      logic [31:0] exp_addr, exp_data;
      int          d;
      for (int i = 4; i > 0; i--) begin
         s_pc[i] = s_pc[i-1]; s_ins[i] = s_ins[i-1];
         s_a[i] = s_a[i-1]; s_b[i] = s_b[i-1]; s_res[i] = s_res[i-1];
      end
      s_pc[0] = m_pc; s_ins[0] = fetch_word(m_pc);
      s_a[0] = 0; s_b[0] = 0; s_res[0] = 0;
      // write-back first, so decode in the same cycle sees it
      d = dest_of(s_ins[4]);
      if (d > 0) mreg[d] = s_res[4];
      // decode reads
      s_a[1] = mreg[s_ins[1][25:21]];
      s_b[1] = mreg[s_ins[1][20:16]];
      // memory stage
      w = s_ins[3];
      sx = {{16{w[15]}}, w[15:0]};
      zx = {16'h0, w[15:0]};
      ea = s_a[3] + sx;
      exp_we = 1'b0; exp_addr = 0; exp_data = 0;
      nxt = m_pc + 32'd4;
      case (w[31:26])
         6'h00: begin
            if (w[5:0] == 6'h21) s_res[3] = s_a[3] + s_b[3];
            else if (w[5:0] == 6'h23) s_res[3] = s_a[3] - s_b[3];
         end
         6'h0D: s_res[3] = s_a[3] | zx;
         6'h23: s_res[3] = mdm[ea[7:2]];
         6'h2B: begin
            exp_we = 1'b1; exp_addr = ea; exp_data = s_b[3];
            mdm[ea[7:2]] = s_b[3];
         end
         6'h04: if (s_a[3] == s_b[3]) nxt = s_pc[3] + 32'd4 + (sx << 2);
         default: ;
      endcase
      check("R2 R6 fetch address", imem_addr, m_pc);
      check("R5 R10 store strobe", {31'h0, dmem_we}, {31'h0, exp_we});
      if (exp_we) begin
         check("R5 store address", dmem_addr, exp_addr);
         check("R5 store data", dmem_wdata, exp_data);
      end
      m_pc = nxt;
   endtask

   task automatic read_reg(input int r, output logic [31:0] v);
      dbg_raddr = r[4:0];
      #0.5;
      v = dbg_rdata;
   endtask

   initial begin
      logic [31:0] v;
      rst_n = 1'b0;
      dbg_raddr = 5'd0;
      for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; mdm[i] = 32'h0; end
      for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
      for (int i = 0; i < 5; i++) begin s_pc[i] = 0; s_ins[i] = 0; s_a[i] = 0; s_b[i] = 0; s_res[i] = 0; end
      m_pc = 32'h0;

      imem[0]  = enc_i(6'h0D, 0, 1, 16'h1234);
      imem[1]  = enc_i(6'h0D, 0, 2, 16'hFFFF);
      imem[2]  = enc_i(6'h0D, 0, 3, 16'h0005);
      imem[3]  = enc_i(6'h0D, 0, 6, 16'h0040);
      imem[4]  = enc_r(1, 2, 4, 6'h21);
      imem[5]  = enc_r(0, 3, 5, 6'h23);
      imem[6]  = enc_i(6'h0D, 0, 0, 16'h0007);
      imem[7]  = enc_i(6'h2B, 6, 4, 16'h0000);
      imem[8]  = enc_i(6'h2B, 6, 5, 16'hFFFC);
      imem[9]  = 32'hFC00_0000;
      imem[10] = enc_i(6'h23, 6, 7, 16'h0000);
      imem[11] = enc_i(6'h23, 6, 8, 16'hFFFC);
      imem[12] = enc_r(1, 2, 16, 6'h2A);
      imem[14] = enc_r(7, 8, 10, 6'h23);
      imem[15] = enc_i(6'h04, 7, 4, 16'h0004);
      imem[16] = enc_i(6'h0D, 0, 11, 16'h0011);
      imem[19] = enc_i(6'h0D, 0, 12, 16'h0BAD);
      imem[20] = enc_i(6'h04, 1, 2, 16'h0008);
      imem[24] = enc_i(6'h0D, 0, 13, 16'h0077);
      imem[25] = enc_r(11, 10, 14, 6'h21);
      imem[26] = enc_r(5, 5, 15, 6'h21);
      imem[27] = enc_i(6'h04, 0, 0, 16'hFFFF);

      repeat (3) @(negedge clk);
      check("R1 fetch address in reset", imem_addr, 32'h0);
      check("R1 store strobe in reset", {31'h0, dmem_we}, 32'h0);
      read_reg(4, v);
      check("R1 register cleared by reset", v, 32'h0);

      rst_n = 1'b1;
      model_step();
      for (int c = 1; c < 90; c++) begin
         @(negedge clk);
         model_step();
      end

      @(negedge clk);
      for (int r = 0; r < 32; r++) begin
         read_reg(r, v);
         check("R7 register file vs model", v, mreg[r]);
      end
      for (int i = 0; i < 64; i++) check("R5 data memory vs model", dmem[i], mdm[i]);

      read_reg(1, v);  check("R4 ori result", v, 32'h0000_1234);
      read_reg(2, v);  check("R4 ori zero-extends", v, 32'h0000_FFFF);
      read_reg(4, v);  check("R3 R8 addu after two-gap", v, 32'h0001_1233);
      read_reg(5, v);  check("R3 subu wraps", v, 32'hFFFF_FFFB);
      read_reg(15, v); check("R3 addu wraps", v, 32'hFFFF_FFF6);
      read_reg(0, v);  check("R9 register 0 stays zero", v, 32'h0);
      read_reg(7, v);  check("R5 load word", v, 32'h0001_1233);
      read_reg(8, v);  check("R5 load negative offset", v, 32'hFFFF_FFFB);
      read_reg(10, v); check("R8 subu of loaded values", v, 32'h0001_1238);
      read_reg(11, v); check("R6 delay slot executes", v, 32'h0000_0011);
      read_reg(12, v); check("R6 taken branch skips", v, 32'h0);
      read_reg(13, v); check("R6 untaken branch falls through", v, 32'h0000_0077);
      read_reg(14, v); check("R7 addu chain", v, 32'h0001_1249);
      read_reg(16, v); check("R10 unknown function writes nothing", v, 32'h0);
      check("R5 stored word", dmem[16], 32'h0001_1233);
      check("R5 stored at negative offset", dmem[15], 32'hFFFF_FFFB);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

endmodule